// File: doc/BRIEF.md
# Vertical Scanline Counter with Split-Screen Addressing

This block keeps the vertical position of a raster display. It advances once for each horizontal line. For every scanline it also produces the frame-buffer byte address at which that line's pixel fetch must begin. The frame length is assembled from byte-wide configuration fields. A mode input chooses between a 10-bit legacy frame length and a 12-bit extended one. Because the programmed length is two less than the real line count, a frame spans the programmed value plus two scanlines.

A programmable compare line splits the screen into two regions:

- **Above the compare line:** lines are fetched starting from a 16-bit start address.
- **From the compare line to the end of the frame:** the address counter restarts at zero, so those lines show the beginning of the frame buffer.

If the compare line is never reached within the frame, the whole frame comes from the start address. Between lines the address grows by a programmable row pitch.

The block is driven by a single line strobe, `line_en`, and holds still between strobes. It has no data stream of its own and therefore no valid/ready handshake. All pins are plain control and status signals, and no back-pressure exists. Every output is registered and changes on the clock edge that samples `line_en` high.

Top module: `vscan_split`

## Requirements
- R1: With `ext_mode`=0 the frame length value is 10 bits: bits 7..0 = `vt_lo`, bit 8 = `ovf[0]`, bit 9 = `ovf[5]`.
- R2: With `ext_mode`=1 the frame length value is 12 bits: bits 7..0 = `vt_lo`, bits 11..8 = `vt_ext[3:0]`. In this mode `ovf[0]` and `ovf[5]` have no effect on the line count.
- R3: `line_num` steps by one on each `line_en`. It runs through the values 0 up to frame length + 1, then returns to 0 on the next `line_en`.
- R4: The compare line is 10 bits: bits 7..0 = `lc_lo`, bit 8 = `ovf[4]`, bit 9 = `msl[6]`.
- R5: On the `line_en` that moves `line_num` onto the compare line, `line_addr` becomes 0. The following lines of the frame then advance from 0 by `row_pitch`.
- R6: On other non-wrapping lines, `line_addr` becomes its previous value plus `row_pitch`, modulo 2^16. The start address is {`start_hi`,`start_lo`}.
- R7: A compare line beyond the last scanline of the frame produces no split: every line derives from the start address.
- R8: On wrap to line 0, `line_addr` reloads the start address present at that edge. Start-address changes made mid-frame do not alter the current frame's addresses.
- R9: Changes to `ext_mode` and to the frame length fields take effect only at the next wrap to line 0.
- R10: `frame_end` is high for exactly one clock, in the cycle after `line_num` reaches the last scanline (frame length + 1).
- R11: With a compare line of 0, line 0 starts at address 0, both after a wrap and after reset.
- R12: While `line_en` is low, `line_num` and `line_addr` hold their values, even if the start address or pitch change.
- R13: Synchronous reset (`rst`=1) sets `line_num` to 0 and `frame_end` to 0. It sets `line_addr` to the start address, or to 0 when the compare line is 0. It also loads the frame length from the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_en | input | 1 | One-cycle strobe per horizontal line |
| ext_mode | input | 1 | 0 = 10-bit frame length, 1 = 12-bit frame length |
| vt_lo | input | 8 | Frame length bits 7..0 |
| ovf | input | 8 | Overflow byte: bit 0 length bit 8, bit 5 length bit 9 (legacy), bit 4 compare bit 8 |
| vt_ext | input | 4 | Frame length bits 11..8 in extended mode |
| lc_lo | input | 8 | Compare line bits 7..0 |
| msl | input | 8 | Byte whose bit 6 is compare line bit 9 |
| start_hi | input | 8 | Start address bits 15..8 |
| start_lo | input | 8 | Start address bits 7..0 |
| row_pitch | input | 16 | Address increment per scanline |
| line_num | output | 13 | Current scanline number |
| frame_end | output | 1 | One-clock pulse on entering the last scanline |
| line_addr | output | 16 | Frame-buffer start address of the current scanline |

## Verification
Every result lands one clock after the edge that sees `line_en` high. This covers the new `line_num`, the new `line_addr` and the `frame_end` pulse. Each strobe therefore yields exactly one expected item. The driver raises `line_en` at a falling edge and drops it just after the rising edge. At that point it applies the requirement rules to the inputs that edge sampled and queues the expected item. The monitor pops the item at the next falling edge, half a period after the outputs moved.

Some checks look at the cycles after a result rather than at the result itself:

- **Reset values:** read at the falling edge after `rst` is released.
- **Single-cycle `frame_end`:** a second falling edge later, with no strobe in between, must show `frame_end` low.
- **Hold behaviour:** several falling edges without a strobe must show unchanged outputs.

// File: rtl/vsc_pkg.sv
package vsc_pkg;
  localparam int VT_W      = 12;          // widest frame length field
  localparam int LCMP_W    = 10;          // compare line width
  localparam int AD_W      = 16;          // frame buffer address width
  localparam int LN_W      = VT_W + 1;    // counter holds length + 1

  // bit positions inside the shared configuration bytes
  localparam int OVF_LEN8  = 0;
  localparam int OVF_LEN9  = 5;
  localparam int OVF_CMP8  = 4;
  localparam int MSL_CMP9  = 6;

  typedef struct packed {
    logic [VT_W-1:0]   len;
    logic [LCMP_W-1:0] cmp;
  } vsc_timing_t;
endpackage

// File: rtl/vsc_field_decode.sv
module vsc_field_decode
  import vsc_pkg::*;
(
  input  logic        ext_mode,
  input  logic [7:0]  vt_lo,
  input  logic [7:0]  ovf,
  input  logic [3:0]  vt_ext,
  input  logic [7:0]  lc_lo,
  input  logic [7:0]  msl,
  output vsc_timing_t timing
);
  localparam int LEG_W = 10;

  logic [LEG_W-1:0] legacy_len;
  logic [VT_W-1:0]  ext_len;

  assign legacy_len = {ovf[OVF_LEN9], ovf[OVF_LEN8], vt_lo};
  assign ext_len    = VT_W'({vt_ext, vt_lo});

  always_comb begin
    timing.len = ext_mode ? ext_len : VT_W'(legacy_len);
    timing.cmp = LCMP_W'({msl[MSL_CMP9], ovf[OVF_CMP8], lc_lo});
  end
endmodule

// File: rtl/vsc_line_counter.sv
module vsc_line_counter
  import vsc_pkg::*;
#(
  parameter int LEN_W = VT_W,
  localparam int CW   = LEN_W + 1
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             line_en,
  input  logic [LEN_W-1:0] len_in,
  output logic [CW-1:0]    cnt,
  output logic [CW-1:0]    cnt_next,
  output logic [LEN_W-1:0] len_act,
  output logic             wrap,
  output logic             step,
  output logic             frame_end
);
  logic at_last;

  assign at_last  = (cnt == CW'(len_act) + CW'(1));
  assign wrap     = line_en & at_last;
  assign step     = line_en & ~at_last;
  assign cnt_next = cnt + CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      len_act   <= len_in;
      frame_end <= 1'b0;
    end else begin
      frame_end <= 1'b0;
      if (wrap) begin
        cnt     <= '0;
        len_act <= len_in;          // mode and length switch here only
      end else if (step) begin
        cnt       <= cnt_next;
        frame_end <= (cnt == CW'(len_act));
      end
    end
  end
endmodule

// File: rtl/vsc_addr_gen.sv
module vsc_addr_gen
  import vsc_pkg::*;
#(
  parameter int CW  = LN_W,
  parameter int CMW = LCMP_W,
  parameter int AW  = AD_W
)(
  input  logic           clk,
  input  logic           rst,
  input  logic           wrap,
  input  logic           step,
  input  logic [CW-1:0]  cnt_next,
  input  logic [CMW-1:0] cmp,
  input  logic [AW-1:0]  start,
  input  logic [AW-1:0]  pitch,
  output logic [AW-1:0]  addr
);
  logic          cmp_zero;
  logic          hit_next;
  logic [AW-1:0] top_addr;

  assign cmp_zero = (cmp == '0);
  assign hit_next = (cnt_next == CW'(cmp));
  assign top_addr = cmp_zero ? '0 : start;

  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      addr <= top_addr;
    end else if (step) begin
      addr <= hit_next ? '0 : addr + pitch;
    end
  end
endmodule

// File: rtl/vscan_split.sv
module vscan_split
  import vsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             line_en,
  input  logic             ext_mode,
  input  logic [7:0]       vt_lo,
  input  logic [7:0]       ovf,
  input  logic [3:0]       vt_ext,
  input  logic [7:0]       lc_lo,
  input  logic [7:0]       msl,
  input  logic [7:0]       start_hi,
  input  logic [7:0]       start_lo,
  input  logic [AD_W-1:0]  row_pitch,
  output logic [LN_W-1:0]  line_num,
  output logic             frame_end,
  output logic [AD_W-1:0]  line_addr
);
  vsc_timing_t       timing;
  logic [VT_W-1:0]   len_act;
  logic [LCMP_W-1:0] lc_val;
  logic [AD_W-1:0]   start_val;
  logic [LN_W-1:0]   cnt_next;
  logic              wrap;
  logic              step;

  assign lc_val    = timing.cmp;
  assign start_val = {start_hi, start_lo};

  vsc_field_decode u_dec (
    .ext_mode (ext_mode),
    .vt_lo    (vt_lo),
    .ovf      (ovf),
    .vt_ext   (vt_ext),
    .lc_lo    (lc_lo),
    .msl      (msl),
    .timing   (timing)
  );

  vsc_line_counter #(.LEN_W(VT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .line_en   (line_en),
    .len_in    (timing.len),
    .cnt       (line_num),
    .cnt_next  (cnt_next),
    .len_act   (len_act),
    .wrap      (wrap),
    .step      (step),
    .frame_end (frame_end)
  );

  vsc_addr_gen #(.CW(LN_W), .CMW(LCMP_W), .AW(AD_W)) u_addr (
    .clk      (clk),
    .rst      (rst),
    .wrap     (wrap),
    .step     (step),
    .cnt_next (cnt_next),
    .cmp      (lc_val),
    .start    (start_val),
    .pitch    (row_pitch),
    .addr     (line_addr)
  );
endmodule

// File: rtl/vscan_split_chk.sv
module vscan_split_chk
  import vsc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              line_en,
  input logic [LN_W-1:0]   line_num,
  input logic              frame_end,
  input logic [AD_W-1:0]   line_addr,
  input logic [VT_W-1:0]   len_act,
  input logic [LCMP_W-1:0] lc_val,
  input logic [AD_W-1:0]   start_val,
  input logic [AD_W-1:0]   pitch
);
  logic on_last;
  logic next_hits;

  assign on_last   = (line_num == LN_W'(len_act) + LN_W'(1));
  assign next_hits = (line_num + LN_W'(1) == LN_W'(lc_val));

  assert_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    line_num <= LN_W'(len_act) + LN_W'(1));

  assert_count_up_R3: assert property (@(posedge clk) disable iff (rst)
    (line_en && !on_last) |=> line_num == $past(line_num) + LN_W'(1));

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (line_en && on_last) |=> line_num == '0);

  assert_split_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (line_en && !on_last && next_hits) |=> line_addr == '0);

  assert_pitch_step_R6: assert property (@(posedge clk) disable iff (rst)
    (line_en && !on_last && !next_hits) |=> line_addr == $past(line_addr) + $past(pitch));

  assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
    (line_en && on_last) |=> line_addr == (($past(lc_val) == '0) ? '0 : $past(start_val)));

  assert_len_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(line_en && on_last) |=> $stable(len_act));

  assert_fe_single_R10: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> !frame_end);

  assert_fe_on_last_R10: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> on_last);

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !line_en |=> ($stable(line_num) && $stable(line_addr)));
endmodule

bind vscan_split vscan_split_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .line_en   (line_en),
  .line_num  (line_num),
  .frame_end (frame_end),
  .line_addr (line_addr),
  .len_act   (len_act),
  .lc_val    (lc_val),
  .start_val (start_val),
  .pitch     (row_pitch)
);

// File: tb/test_vscan_split.sv
`timescale 1ns/1ps
module test_vscan_split;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        line_en = 1'b0;
  logic        ext_mode = 1'b0;
  logic [7:0]  vt_lo = 8'd5;
  logic [7:0]  ovf = 8'h00;
  logic [3:0]  vt_ext = 4'h0;
  logic [7:0]  lc_lo = 8'd3;
  logic [7:0]  msl = 8'h00;
  logic [7:0]  start_hi = 8'h12;
  logic [7:0]  start_lo = 8'h00;
  logic [15:0] row_pitch = 16'h0040;
  logic [12:0] line_num;
  logic        frame_end;
  logic [15:0] line_addr;

  always #2.5 clk = ~clk;

  vscan_split i_vscan_split (
    .clk(clk), .rst(rst), .line_en(line_en), .ext_mode(ext_mode),
    .vt_lo(vt_lo), .ovf(ovf), .vt_ext(vt_ext), .lc_lo(lc_lo), .msl(msl),
    .start_hi(start_hi), .start_lo(start_lo), .row_pitch(row_pitch),
    .line_num(line_num), .frame_end(frame_end), .line_addr(line_addr)
  );

  typedef struct {
    int          cnt;
    logic [15:0] addr;
    logic        fe;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  int          m_cnt, m_len;
  logic [15:0] m_addr;
  logic        m_fe;
  bit          m_wrap;
  string       cur_tag;

  function automatic int want_len();
    if (ext_mode) return int'({vt_ext, vt_lo});
    return int'({ovf[5], ovf[0], vt_lo});
  endfunction

  function automatic int want_cmp();
    return int'({msl[6], ovf[4], lc_lo});
  endfunction

  function automatic logic [15:0] top_addr();
    return (want_cmp() == 0) ? 16'h0 : {start_hi, start_lo};
  endfunction

  task automatic check(input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // monitor: compare one queued item per falling edge
  always @(negedge clk) begin
    exp_t e;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      check(e.tag, "line_num",  line_num,  e.cnt);
      check(e.tag, "line_addr", line_addr, e.addr);
      check(e.tag, "frame_end", frame_end, e.fe);
    end
  end

  // driver: one line strobe, expected result pushed after the edge
  task automatic line_step();
    exp_t e;
    @(negedge clk);
    line_en = 1'b1;
    @(posedge clk);
    #1;
    line_en = 1'b0;
    m_wrap = (m_cnt == m_len + 1);
    if (m_wrap) begin
      m_cnt  = 0;
      m_len  = want_len();
      m_addr = top_addr();
    end else begin
      m_cnt++;
      m_addr = (m_cnt == want_cmp()) ? 16'h0 : m_addr + row_pitch;
    end
    m_fe   = (m_cnt == m_len + 1);
    e.cnt  = m_cnt;
    e.addr = m_addr;
    e.fe   = m_fe;
    e.tag  = cur_tag;
    sb.push_back(e);
  endtask

  task automatic run_lines(input int n);
    for (int i = 0; i < n; i++) line_step();
  endtask

  task automatic run_frames(input int n);
    int w = 0;
    while (w < n) begin
      line_step();
      if (m_wrap) w++;
    end
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R13 reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_len = want_len(); m_addr = top_addr(); m_fe = 1'b0;
    @(negedge clk);
    check("R13", "line_num",  line_num,  0);
    check("R13", "line_addr", line_addr, 16'h1200);
    check("R13", "frame_end", frame_end, 0);

    // short legacy frame of 7 lines, split at line 3
    cur_tag = "R3/R5/R6";
    run_lines(16);
    drain();

    // R10 pulse lasts one clock
    cur_tag = "R10";
    while (!m_fe) line_step();
    drain();
    @(negedge clk);
    check("R10", "frame_end low after pulse", frame_end, 0);

    // R12 idle lines hold outputs despite changing start and pitch
    begin
      logic [12:0] n0;
      logic [15:0] a0;
      n0 = line_num; a0 = line_addr;
      start_hi = 8'h77; row_pitch = 16'h0123;
      repeat (5) @(negedge clk);
      check("R12", "line_num hold",  line_num,  n0);
      check("R12", "line_addr hold", line_addr, a0);
      start_hi = 8'h12; row_pitch = 16'h0040;
    end

    // R8 mid-frame start change applies at wrap only
    cur_tag = "R8";
    run_lines(2);
    start_hi = 8'h33; start_lo = 8'h30;
    run_frames(2);
    drain();

    // R7 compare beyond frame: no split
    cur_tag = "R7";
    lc_lo = 8'hF0;
    run_frames(2);
    drain();

    // R11 compare line zero
    cur_tag = "R11";
    lc_lo = 8'h00;
    run_frames(2);
    drain();

    // R1 + R9: legacy length bit 8, changed mid-frame
    cur_tag = "R1/R9";
    lc_lo = 8'h20; row_pitch = 16'h0100;
    run_lines(2);
    ovf = 8'h01; vt_lo = 8'h10;
    run_frames(2);
    cur_tag = "R1";
    ovf = 8'h21;                 // adds bit 9
    run_frames(2);
    drain();

    // R2 + R9: extended mode, ovf length bits must not matter
    cur_tag = "R2/R9";
    ext_mode = 1'b1; vt_ext = 4'h2; vt_lo = 8'h10; ovf = 8'h21;
    msl = 8'h40; lc_lo = 8'h05;   // compare 0x205 (R4 bit 9)
    run_frames(2);
    drain();

    // R4 compare bit 8 from ovf[4]
    cur_tag = "R4";
    ovf = 8'h10; msl = 8'h00;     // compare 0x105
    run_frames(2);
    drain();

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule